// File: doc/BRIEF.md
# Alarm Time Register and Match Detector

This block keeps an alarm time (hour and minute) beside a running time-of-day counter and reports when the two agree. The alarm time is adjusted with the same hour-select, minute-select and step controls that normally set the clock. A dedicated edit switch routes those controls here. While the edit switch is low, the controls have no effect on this block.

Once per second the block compares the clock's hour and minute with the stored alarm. The comparison uses the hour format in force at that moment. When the clock's seconds read zero and both fields agree, the block raises a single-cycle pulse.

The block carries no data stream, so it has no valid/ready interface. Every pin is a plain level or strobe sampled on the rising clock edge.

Top module: `alarm_matcher`

## Requirements
- R1: A synchronous active-high `rst` sets `alm_hour` to 0 and `alm_min` to 0, and holds `alm_fire` low.
- R2: With `alm_edit` high, a `bump` strobe with `sel_hour` high advances `alm_hour` by one. In 24-hour mode (`fmt24`=1) the hour wraps from 23 to 0. In 12-hour mode (`fmt24`=0) any hour of 11 or more steps to 0.
- R3: With `alm_edit` high, a `bump` strobe with `sel_min` high and `sel_hour` low advances `alm_min` by one, wrapping from 59 to 0.
- R4: When `sel_hour` and `sel_min` are both high during an edit `bump`, only the hour changes.
- R5: A `bump` strobe while `alm_edit` is low leaves `alm_hour` and `alm_min` unchanged.
- R6: `alm_fire` is high for exactly the one cycle that follows a cycle in which all of these hold: `tick` is high, `clk_sec` is 0, and the clock's hour and minute equal the alarm's (24-hour mode).
- R7: No pulse follows a tick when `clk_sec` is not 0, when the minute differs, or when `tick` is low. Seconds are never compared with the alarm.
- R8: In 12-hour mode, both hours are reduced modulo 12 before comparison, so alarm 15 matches clock hour 3.
- R9: No pulse is raised for a tick seen while `alm_edit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe, once per second |
| clk_hour | input | 5 | Running clock hour |
| clk_min | input | 6 | Running clock minute |
| clk_sec | input | 6 | Running clock second |
| fmt24 | input | 1 | 1 = 24-hour format, 0 = 12-hour format |
| alm_edit | input | 1 | Routes set controls to the alarm |
| sel_hour | input | 1 | Step targets the hour |
| sel_min | input | 1 | Step targets the minute |
| bump | input | 1 | One-cycle step strobe |
| alm_hour | output | 5 | Stored alarm hour |
| alm_min | output | 6 | Stored alarm minute |
| alm_fire | output | 1 | One-cycle match pulse |

## Verification
The embedded properties assume that `tick` and `bump` are single-cycle strobes. They also assume that the clock fields stay within their ranges (hour below 24, minute and second below 60). The stimulus raises each strobe for exactly one cycle, framed by idle cycles. It drives only in-range clock values. When it switches format, it does so on cycles without a tick or step, so the fire and wrap properties see stable mode inputs.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  parameter int HOUR_W     = 5;
  parameter int MIN_W      = 6;
  parameter int HOURS_FULL = 24;
  parameter int HOURS_HALF = 12;
  parameter int MINUTES    = 60;
  typedef logic [HOUR_W-1:0] hour_t;
  typedef logic [MIN_W-1:0]  min_t;
endpackage

// File: rtl/alarm_hour_fold.sv
module alarm_hour_fold
  import alarm_pkg::*;
(
  input  hour_t hour_in,
  input  logic  fold,
  output hour_t hour_out
);
  localparam hour_t HALF_V = hour_t'(HOURS_HALF);

  always_comb begin
    if (fold && hour_in >= HALF_V) hour_out = hour_in - HALF_V;
    else                           hour_out = hour_in;
  end
endmodule

// File: rtl/alarm_store.sv
module alarm_store
  import alarm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fmt24,
  input  logic  alm_edit,
  input  logic  sel_hour,
  input  logic  sel_min,
  input  logic  bump,
  output hour_t alm_hour,
  output min_t  alm_min
);
  localparam hour_t FULL_TOP = hour_t'(HOURS_FULL - 1);
  localparam hour_t HALF_TOP = hour_t'(HOURS_HALF - 1);
  localparam min_t  MIN_TOP  = min_t'(MINUTES - 1);

  hour_t hour_top;
  logic  step;

  assign hour_top = fmt24 ? FULL_TOP : HALF_TOP;
  assign step     = alm_edit && bump;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_hour <= '0;
      alm_min  <= '0;
    end else if (step) begin
      if (sel_hour) begin
        alm_hour <= (alm_hour >= hour_top) ? '0 : alm_hour + 1'b1;
      end else if (sel_min) begin
        alm_min  <= (alm_min >= MIN_TOP) ? '0 : alm_min + 1'b1;
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_min_range_R3: assert property (@(posedge clk) disable iff (rst)
    alm_min <= MIN_TOP);
  assert_hour_range_R2: assert property (@(posedge clk) disable iff (rst)
    alm_hour <= FULL_TOP);
  assert_min_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (alm_edit && bump && sel_min && !sel_hour && alm_min == MIN_TOP) |=> alm_min == '0);
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(alm_edit) |-> ($stable(alm_hour) && $stable(alm_min)));
  assert_hour_first_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(sel_hour) |-> $stable(alm_min));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  fmt24,
  input  logic  alm_edit,
  input  hour_t clk_hour,
  input  min_t  clk_min,
  input  min_t  clk_sec,
  input  hour_t alm_hour,
  input  min_t  alm_min,
  output logic  alm_fire
);
  hour_t folded [2];
  hour_t raw    [2];

  assign raw[0] = clk_hour;
  assign raw[1] = alm_hour;

  for (genvar g = 0; g < 2; g++) begin : g_fold
    alarm_hour_fold u_fold (
      .hour_in  (raw[g]),
      .fold     (!fmt24),
      .hour_out (folded[g])
    );
  end

  logic agree;
  assign agree = (folded[0] == folded[1]) && (clk_min == alm_min) && (clk_sec == '0);

  always_ff @(posedge clk) begin
    if (rst) alm_fire <= 1'b0;
    else     alm_fire <= tick && !alm_edit && agree;
  end

  assert_fire_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
    alm_fire |-> $past(tick));
  assert_fire_single_R6: assert property (@(posedge clk) disable iff (rst)
    alm_fire |=> !alm_fire);
  assert_quiet_in_edit_R9: assert property (@(posedge clk) disable iff (rst)
    alm_fire |-> !$past(alm_edit));
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [HOUR_W-1:0] clk_hour,
  input  logic [MIN_W-1:0]  clk_min,
  input  logic [MIN_W-1:0]  clk_sec,
  input  logic              fmt24,
  input  logic              alm_edit,
  input  logic              sel_hour,
  input  logic              sel_min,
  input  logic              bump,
  output logic [HOUR_W-1:0] alm_hour,
  output logic [MIN_W-1:0]  alm_min,
  output logic              alm_fire
);
  alarm_store u_store (
    .clk      (clk),
    .rst      (rst),
    .fmt24    (fmt24),
    .alm_edit (alm_edit),
    .sel_hour (sel_hour),
    .sel_min  (sel_min),
    .bump     (bump),
    .alm_hour (alm_hour),
    .alm_min  (alm_min)
  );

  alarm_match u_match (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .fmt24    (fmt24),
    .alm_edit (alm_edit),
    .clk_hour (clk_hour),
    .clk_min  (clk_min),
    .clk_sec  (clk_sec),
    .alm_hour (alm_hour),
    .alm_min  (alm_min),
    .alm_fire (alm_fire)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (alm_hour == '0 && alm_min == '0 && !alm_fire));
endmodule

// File: tb/sim_alarm_matcher.sv
module sim_alarm_matcher;
  logic clk = 0, rst = 1, tick = 0, fmt24 = 1, alm_edit = 0, sel_hour = 0, sel_min = 0, bump = 0;
  logic [4:0] clk_hour = 0;
  logic [5:0] clk_min = 0, clk_sec = 0;
  logic [4:0] alm_hour;
  logic [5:0] alm_min;
  logic alm_fire;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_matcher u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bumps(logic e, logic sh, logic sm, int n);
    alm_edit = e; sel_hour = sh; sel_min = sm;
    for (int i = 0; i < n; i++) begin
      bump = 1; @(negedge clk);
      bump = 0; @(negedge clk);
    end
    sel_hour = 0; sel_min = 0; alm_edit = 0;
  endtask

  task automatic do_reset;
    rst = 1; idle(2); rst = 0; idle(1);
  endtask

  // Pulses tick once; returns fire seen in the cycle after and the one following.
  task automatic fire_probe(input logic [4:0] h, input logic [5:0] m, input logic [5:0] s,
                            output int first, output int second);
    clk_hour = h; clk_min = m; clk_sec = s;
    @(negedge clk);
    tick = 1; @(negedge clk);
    tick = 0; first = alm_fire;
    @(negedge clk); second = alm_fire;
  endtask

  task automatic t_reset;
    bumps(1, 1, 0, 3); bumps(1, 0, 1, 4);
    do_reset;
    chk("R1 hour", alm_hour, 0);
    chk("R1 min", alm_min, 0);
    chk("R1 fire", alm_fire, 0);
  endtask

  task automatic t_hour24;
    do_reset; fmt24 = 1;
    bumps(1, 1, 0, 23); chk("R2 hour reaches 23", alm_hour, 23);
    bumps(1, 1, 0, 1);  chk("R2 24h wrap", alm_hour, 0);
  endtask

  task automatic t_hour12;
    do_reset; fmt24 = 0;
    bumps(1, 1, 0, 11); chk("R2 hour reaches 11", alm_hour, 11);
    bumps(1, 1, 0, 1);  chk("R2 12h wrap", alm_hour, 0);
    fmt24 = 1; bumps(1, 1, 0, 15); fmt24 = 0; idle(1);
    bumps(1, 1, 0, 1);  chk("R2 12h from 15", alm_hour, 0);
    fmt24 = 1;
  endtask

  task automatic t_minute;
    do_reset;
    bumps(1, 0, 1, 59); chk("R3 min reaches 59", alm_min, 59);
    bumps(1, 0, 1, 1);  chk("R3 min wrap", alm_min, 0);
  endtask

  task automatic t_priority;
    do_reset;
    bumps(1, 1, 1, 2);
    chk("R4 hour moved", alm_hour, 2);
    chk("R4 min held", alm_min, 0);
  endtask

  task automatic t_ignore;
    do_reset;
    bumps(1, 1, 0, 4); bumps(1, 0, 1, 7);
    bumps(0, 1, 0, 3); bumps(0, 0, 1, 3);
    chk("R5 hour kept", alm_hour, 4);
    chk("R5 min kept", alm_min, 7);
  endtask

  task automatic t_fire24;
    int a, b;
    do_reset; fmt24 = 1;
    bumps(1, 1, 0, 18); bumps(1, 0, 1, 45);
    fire_probe(18, 45, 0, a, b);
    chk("R6 pulse", a, 1);
    chk("R6 one cycle", b, 0);
  endtask

  task automatic t_nomatch;
    int a, b;
    fire_probe(18, 45, 1, a, b);  chk("R7 sec nonzero", a, 0);
    fire_probe(18, 44, 0, a, b);  chk("R7 min differs", a, 0);
    fire_probe(6, 45, 0, a, b);   chk("R8 24h no fold", a, 0);
    clk_sec = 0; idle(3);         chk("R7 no tick", alm_fire, 0);
  endtask

  task automatic t_fire12;
    int a, b;
    do_reset; fmt24 = 1;
    bumps(1, 1, 0, 15); bumps(1, 0, 1, 30);
    fmt24 = 0; idle(1);
    fire_probe(3, 30, 0, a, b);
    chk("R8 12h fold match", a, 1);
    fmt24 = 1; idle(1);
  endtask

  task automatic t_suppress;
    int a, b;
    alm_edit = 1;
    fire_probe(15, 30, 0, a, b);
    alm_edit = 0;
    chk("R9 quiet in edit", a, 0);
    fire_probe(15, 30, 0, a, b);
    chk("R9 fires after edit", a, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset; t_hour24; t_hour12; t_minute; t_priority; t_ignore;
    t_fire24; t_nomatch; t_fire12; t_suppress;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule